// File: doc/BRIEF.md
# Parity-Checked SPI Register Bank Slave

This block is an SPI slave that gives an external master access to a bank of 8-bit user registers. Each command is a frame of exactly three bytes, sent while chip-select is held low. The first byte is an opcode. For a write, the second byte is the data. The third byte holds a 4-bit register address followed by an odd and an even parity bit, both computed over the data and the address. For a read, the address is the upper nibble of the second byte. A write whose parity bits do not match is dropped, and the failure is recorded in a sticky flag of the status byte.

While the master shifts a command in, the slave shifts three bytes out on the same frame. The first is the status byte. The second is the opcode the slave has just received. The third is the addressed register's contents on a read, and zero for every other command. The SPI pins are brought into the system clock domain through synchroniser chains, and the SCK edges are detected there, so SCK must be several times slower than the system clock. Register 0 is a read-only identification register.

Top module: `spi_regbank_slave`

## Requirements
- R1: The bus runs in SPI mode 0 with chip-select active low. MOSI is sampled on the SCK rising edge. MISO changes after the SCK falling edge, and both directions carry the most significant bit first.
- R2: The first byte on MISO in every frame is the status byte. Bit 7 is the parity-error flag, bit 6 is the unknown-opcode flag, and bits 5..0 read 0. The value sent is the flags as they stand at the first SCK edge of the frame.
- R3: The second byte on MISO is a copy of the opcode byte that the master sent at the start of the same frame.
- R4: A complete frame with opcode 8'h87, data D in byte 2, and byte 3 = {A[3:0], P1, P0, 2'b00} writes D into register A. This requires P0 = XOR of D and A, and P1 = NOT P0.
- R5: If either received parity bit differs from its expected value, register A is left unchanged and status bit 7 is set.
- R6: A complete frame with opcode 8'h86 and A in bits 7..4 of byte 2 returns register A as the third MISO byte. For a write, a NOP (8'h00) or an unknown opcode, the third byte is 8'h00.
- R7: Any opcode other than 8'h87, 8'h86 or 8'h00 sets status bit 6 and accesses no register.
- R8: Status bits 7 and 6 stay set until a complete frame has returned them set in its status byte. They then clear at the end of that frame, unless the same frame raises them again.
- R9: If chip-select goes high before the 24th SCK rising edge, the frame is aborted. It writes nothing and clears no flag.
- R10: Register 0 always reads 8'hA5, and writes to it are ignored.
- R11: After reset, registers 1 to 15 read 8'h00 and both flags are clear. MISO is 0 whenever chip-select is high.
- R12: A NOP frame changes no register and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip-select that frames a command |
| spi_miso | output | 1 | Serial data to the master, 0 while not selected |

## Verification
Internal faults reach the pins within a frame or two:
- A wrong bit count or a wrong shift direction corrupts the opcode echo in the second byte of the same frame.
- A wrong parity decision or a wrong write address shows in the third byte of the next read of that address.
- A flag that fails to set, sets when it should not, or clears at the wrong time shows in the status byte of the very next frame, including the frame that follows an aborted one.

The reference model predicts all 24 MISO bits of every frame. Between frames it also checks that MISO stays low on every clock.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
   localparam int BYTE_W      = 8;
   localparam int FRAME_BYTES = 3;
   localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
   localparam int CNT_W       = $clog2(FRAME_BITS + 1);
   localparam int NIB_W       = 4;

   localparam logic [BYTE_W-1:0] OP_WRITE = 8'h87;
   localparam logic [BYTE_W-1:0] OP_READ  = 8'h86;
   localparam logic [BYTE_W-1:0] OP_NOP   = 8'h00;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_WRITE,
      CMD_READ,
      CMD_BAD
   } cmd_e;

   typedef struct packed {
      logic par_err;
      logic op_err;
   } flags_t;

   function automatic cmd_e decode_op(input logic [BYTE_W-1:0] op);
      case (op)
         OP_WRITE: return CMD_WRITE;
         OP_READ:  return CMD_READ;
         OP_NOP:   return CMD_NOP;
         default:  return CMD_BAD;
      endcase
   endfunction

   function automatic logic even_bit(input logic [BYTE_W-1:0] d, input logic [NIB_W-1:0] a);
      return ^{d, a};
   endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic mosi,
   input  logic cs_n,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s,
   output logic cs_act
);
   localparam int LAST = STAGES - 1;
   // lane order: {cs_n, mosi, sck}
   localparam logic [2:0] IDLE = 3'b100;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [2:0] stg [STAGES];
   logic       sck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= IDLE;
         sck_last <= 1'b0;
      end else begin
         stg[0] <= {cs_n, mosi, sck};
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         sck_last <= stg[LAST][0];
      end
   end

   assign sck_rise = stg[LAST][0] & ~sck_last;
   assign sck_fall = ~stg[LAST][0] & sck_last;
   assign mosi_s   = stg[LAST][1];
   assign cs_act   = ~stg[LAST][2];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_s,
   input  logic              cs_act,
   input  logic [BYTE_W-1:0] status_live,
   input  logic [BYTE_W-1:0] tail_byte,
   output logic [BYTE_W-1:0] op_q,
   output logic [BYTE_W-1:0] b1_q,
   output logic [BYTE_W-1:0] b2_q,
   output logic [BYTE_W-1:0] stat_cap,
   output logic              done,
   output logic [CNT_W-1:0]  in_cnt,
   output logic [CNT_W-1:0]  out_idx,
   output logic              miso
);
   localparam logic [CNT_W-1:0] END_B0 = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] END_B1 = CNT_W'(2 * BYTE_W - 1);
   localparam logic [CNT_W-1:0] END_B2 = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME_BITS);

   logic [BYTE_W-2:0] sr;
   logic [BYTE_W-1:0] cur;
   logic [BYTE_W-1:0] rx_byte;

   assign rx_byte = {sr, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cnt   <= '0;
         out_idx  <= '0;
         sr       <= '0;
         op_q     <= '0;
         b1_q     <= '0;
         b2_q     <= '0;
         stat_cap <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!cs_act) begin
            in_cnt  <= '0;
            out_idx <= '0;
         end else begin
            if (sck_rise && (in_cnt < FULL)) begin
               in_cnt <= in_cnt + 1'b1;
               sr     <= rx_byte[BYTE_W-2:0];
               if (in_cnt == '0) stat_cap <= status_live;
               if (in_cnt == END_B0) op_q <= rx_byte;
               if (in_cnt == END_B1) b1_q <= rx_byte;
               if (in_cnt == END_B2) begin
                  b2_q <= rx_byte;
                  done <= 1'b1;
               end
            end
            if (sck_fall && (out_idx < FULL)) out_idx <= out_idx + 1'b1;
         end
      end
   end

   always_comb begin
      case (out_idx[CNT_W-1:3])
         2'd0:    cur = (in_cnt == '0) ? status_live : stat_cap;
         2'd1:    cur = op_q;
         2'd2:    cur = tail_byte;
         default: cur = '0;
      endcase
   end

   assign miso = cs_act & cur[~out_idx[2:0]];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_regbank_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [BYTE_W-1:0] op_q,
   input  logic [BYTE_W-1:0] b1_q,
   input  logic [BYTE_W-1:0] b2_q,
   input  logic [BYTE_W-1:0] stat_cap,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_req,
   output logic [BYTE_W-1:0] status
);
   cmd_e             cmd;
   flags_t           fl;
   logic [NIB_W-1:0] w_nib;
   logic [NIB_W-1:0] r_nib;
   logic             p_odd;
   logic             p_even;
   logic             exp_even;
   logic             par_ok;
   logic             w_in;
   logic             r_in;
   logic             unused_bits;

   assign cmd      = decode_op(op_q);
   assign w_nib    = b2_q[BYTE_W-1 -: NIB_W];
   assign p_odd    = b2_q[BYTE_W-NIB_W-1];
   assign p_even   = b2_q[BYTE_W-NIB_W-2];
   assign r_nib    = b1_q[BYTE_W-1 -: NIB_W];
   assign exp_even = even_bit(b1_q, w_nib);
   assign par_ok   = (p_even == exp_even) && (p_odd == ~exp_even);
   assign unused_bits = ^{b2_q[1:0], b1_q[BYTE_W-NIB_W-1:0], stat_cap[BYTE_W-3:0]};

   generate
      if (ADDR_W == NIB_W) begin : g_full_map
         assign w_in = 1'b1;
         assign r_in = 1'b1;
      end else begin : g_part_map
         assign w_in = (w_nib[NIB_W-1:ADDR_W] == '0);
         assign r_in = (r_nib[NIB_W-1:ADDR_W] == '0);
      end
   endgenerate

   assign wr_addr = w_nib[ADDR_W-1:0];
   assign wr_data = b1_q;
   assign rd_addr = r_nib[ADDR_W-1:0];
   assign rd_req  = (cmd == CMD_READ) && r_in;
   assign wr_en   = done && (cmd == CMD_WRITE) && par_ok && w_in && (wr_addr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl <= '0;
      end else if (done) begin
         fl.par_err <= (fl.par_err & ~stat_cap[BYTE_W-1]) | ((cmd == CMD_WRITE) & ~par_ok);
         fl.op_err  <= (fl.op_err  & ~stat_cap[BYTE_W-2]) | (cmd == CMD_BAD);
      end
   end

   assign status = {fl.par_err, fl.op_err, {(BYTE_W-2){1'b0}}};
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spi_regbank_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         if (i == 0) begin : g_id
            assign q[i] = ID_VALUE;
         end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                              q[i] <= '0;
               else if (wr_en && (wr_addr == ADDR_W'(i))) q[i] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = q[rd_addr];
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
   import spi_regbank_pkg::*;
#(
   parameter int                ADDR_W      = 4,
   parameter int                SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] ID_VALUE    = 8'hA5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   input  logic spi_cs_n,
   output logic spi_miso
);
   generate
      if (ADDR_W < 1 || ADDR_W > NIB_W) begin : g_bad_addr
         $error("spi_regbank_slave: ADDR_W must lie in 1..4");
      end
   endgenerate

   logic              sck_rise, sck_fall, mosi_s, cs_act;
   logic [BYTE_W-1:0] op_q, b1_q, b2_q, stat_cap, status, rd_data, tail_byte, wr_data;
   logic              done, wr_en, rd_req;
   logic [CNT_W-1:0]  in_cnt, out_idx;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .cs_act(cs_act)
   );

   spi_frame_engine u_frame (
      .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .mosi_s(mosi_s), .cs_act(cs_act), .status_live(status), .tail_byte(tail_byte),
      .op_q(op_q), .b1_q(b1_q), .b2_q(b2_q), .stat_cap(stat_cap), .done(done),
      .in_cnt(in_cnt), .out_idx(out_idx), .miso(spi_miso)
   );

   spi_cmd_ctrl #(.ADDR_W(ADDR_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .done(done), .op_q(op_q), .b1_q(b1_q), .b2_q(b2_q),
      .stat_cap(stat_cap), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_req(rd_req), .status(status)
   );

   spi_regfile #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign tail_byte = rd_req ? rd_data : '0;
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk
   import spi_regbank_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              done,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BYTE_W-1:0] status,
   input logic [BYTE_W-1:0] op_q,
   input logic [BYTE_W-1:0] b2_q,
   input logic [CNT_W-1:0]  in_cnt,
   input logic [CNT_W-1:0]  out_idx,
   input logic              miso
);
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !miso);

   a_r10_id_locked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr != '0));

   a_r5_bad_parity_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == 8'h87 && (b2_q[2] == b2_q[3])) |-> !wr_en);

   a_r5_bad_parity_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == 8'h87 && (b2_q[2] == b2_q[3])) |=> status[7]);

   a_r7_bad_opcode_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q != 8'h87 && op_q != 8'h86 && op_q != 8'h00) |=> (status[6] && !$past(wr_en)));

   a_r9_write_needs_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> done);

   a_r8_flags_move_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(status));

   a_r9_abort_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (in_cnt == '0 && out_idx == '0));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .done(done), .wr_en(wr_en),
   .wr_addr(wr_addr), .status(status), .op_q(op_q), .b2_q(b2_q),
   .in_cnt(in_cnt), .out_idx(out_idx), .miso(spi_miso)
);

// File: tb/spi_regbank_slave_test.sv
module spi_regbank_slave_test;
   localparam int HALF = 8;
   localparam int WD   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic cs_n = 1'b1;
   logic miso;

   int n_cmp = 0;
   int n_bad = 0;
   int idle_cyc = 0;

   // reference model state
   logic [7:0] m_reg [16];
   bit m_par = 0;
   bit m_op = 0;

   always #10 clk = ~clk;

   spi_regbank_slave uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_cs_n(cs_n), .spi_miso(miso)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // R11: MISO stays low while deselected, compared on every clock
   always @(negedge clk) begin
      if (!rst_n || !cs_n) idle_cyc = 0;
      else begin
         idle_cyc++;
         if (idle_cyc > 6) check("R11 idle miso", {7'd0, miso}, 8'd0);
      end
   end

   function automatic logic [7:0] ctl3(input logic [3:0] a, input logic [7:0] d);
      logic pe;
      pe = ^{d, a};
      return {a, ~pe, pe, 2'b00};
   endfunction

   // R1: mode 0, MSB first; MISO sampled just before each rising edge
   task automatic frame(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                        input int nbits, input string tail_tag);
      logic [23:0] word, got, exp;
      logic [7:0] e0, e2;
      logic pe;
      e0 = {m_par, m_op, 6'd0};
      e2 = (op == 8'h86) ? m_reg[b1[7:4]] : 8'h00;
      word = {op, b1, b2};
      exp = {e0, op, e2};
      got = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = word[23-i];
         repeat (HALF) @(negedge clk);
         got[23-i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (2 * HALF) @(negedge clk);
      if (nbits >= 8)  check("R2 R8 status byte", got[23:16], exp[23:16]);
      if (nbits >= 16) check("R1 R3 opcode echo", got[15:8], exp[15:8]);
      if (nbits >= 24) check(tail_tag, got[7:0], exp[7:0]);
      if (nbits == 24) begin
         if (e0[7]) m_par = 0;
         if (e0[6]) m_op = 0;
         if (op == 8'h87) begin
            pe = ^{b1, b2[7:4]};
            if (b2[2] == pe && b2[3] == ~pe) begin
               if (b2[7:4] != 4'd0) m_reg[b2[7:4]] = b1;
            end else m_par = 1;
         end else if (op != 8'h86 && op != 8'h00) m_op = 1;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [7:0] flip, input string tag);
      frame(8'h87, d, ctl3(a, d) ^ flip, 24, tag);
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      frame(8'h86, {a, 4'h0}, 8'h00, 24, tag);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      m_reg[0] = 8'hA5;
      for (int i = 1; i < 16; i++) m_reg[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R11 miso after reset", {7'd0, miso}, 8'd0);

      frame(8'h00, 8'h00, 8'h00, 24, "R12 NOP tail");
      rd(4'd0, "R10 id read");
      for (int a = 1; a < 16; a++) rd(4'(a), "R11 reset value");

      wr(4'd5, 8'h3C, 8'h00, "R6 write tail");
      rd(4'd5, "R4 readback");

      // bad even bit
      wr(4'd9, 8'hC3, 8'h04, "R6 write tail");
      rd(4'd9, "R5 unchanged after bad P0");
      rd(4'd9, "R8 flag cleared");
      // bad odd bit
      wr(4'd5, 8'h77, 8'h08, "R6 write tail");
      rd(4'd5, "R5 unchanged after bad P1");
      // both bits wrong
      wr(4'd6, 8'h01, 8'h0C, "R6 write tail");
      rd(4'd6, "R5 unchanged after swapped parity");

      frame(8'h55, 8'h12, 8'h34, 24, "R7 unknown opcode tail");
      rd(4'd1, "R7 no access");
      frame(8'hFF, 8'h5A, 8'h50, 24, "R7 unknown opcode tail");
      wr(4'd3, 8'hE1, 8'h40, "R6 write tail");
      rd(4'd3, "R8 both flags reported");
      rd(4'd3, "R8 flags cleared");

      wr(4'd0, 8'h11, 8'h00, "R6 write tail");
      rd(4'd0, "R10 write ignored");

      // abort with flag set: flag must survive
      wr(4'd2, 8'h00, 8'h04, "R6 write tail");
      frame(8'h00, 8'h00, 8'h00, 12, "R9 abort");
      rd(4'd2, "R9 flag kept after abort");
      // aborted valid write must not land
      frame(8'h87, 8'h99, ctl3(4'd7, 8'h99), 20, "R9 abort");
      frame(8'h87, 8'h99, ctl3(4'd7, 8'h99), 23, "R9 abort");
      rd(4'd7, "R9 no write on abort");

      frame(8'h00, 8'hFF, 8'hFF, 24, "R12 NOP tail");
      rd(4'd5, "R12 NOP no change");

      for (int a = 1; a < 16; a++) wr(4'(a), 8'(a * 37 + 11), 8'h00, "R6 write tail");
      for (int a = 0; a < 16; a++) rd(4'(a), "R4 sweep readback");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule